// File: doc/BRIEF.md
# Serial Port Receive-FIFO Register Front End

This block is the register-side front end of a byte-oriented serial port. Software reaches it over a small byte-wide bus and uses it to set the line mode, the bit-rate divisor, the enables and the receive-FIFO behaviour. A byte written to the transmit data offset leaves the block as a one-cycle strobe with data, which a serializer outside this block takes. Received bytes come in on a valid/ready stream and are stored in a 16-entry circular FIFO. Software pops them from a data offset and can read the current fill level at any time.

A programmable trigger level controls a receive-data-full flag. The flag sets when a push brings the fill level up to the trigger and clears only when a pop takes the level below it. When receive interrupts are enabled, the same push condition raises a level interrupt. Status flags are cleared by writing zero to their bit positions. A status read made while the transmitter is enabled re-arms the two transmit flags.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, the register reads are: bit rate (0x04) 0xFF, control (0x08) 0x20, mode (0x00) 0x00, port (0x20) 0x00, status (0x10) 0x60, receive count (0x1C) 0x00. The interrupt is low and the trigger level is 1.
- R2: Writes are masked. Mode keeps the bits in 0x7B, control keeps 0xFA and port keeps 0xF3, and each register reads back its masked value.
- R3: The FIFO control offset is 0x18. Bits 7:6 set the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Writing 1 to bit 1 empties the FIFO, clears receive-data-full, and takes priority over a push in the same cycle.
- R4: The FIFO holds 16 bytes. Bytes pop from offset 0x14 in arrival order, and offset 0x1C returns the count. A byte that arrives while the FIFO is full is dropped.
- R5: rx_ready follows control bit 4. While that bit is 0, arriving bytes are not stored.
- R6: Receive-data-full (status bit 1) sets when a push leaves count ≥ trigger. It clears when a pop leaves count < trigger. Otherwise it holds.
- R7: rx_irq sets when a push leaves count ≥ trigger while control bit 6 is 1. It stays set until one of two writes clears it: a control write with bit 6 = 0, or a status write with bit 1 or bit 0 = 0. A clear wins over a set in the same cycle.
- R8: The status layout is: transmit-end at bit 6, transmit-data-empty at bit 5, break at bit 4, receive-data-full at bit 1, data-ready at bit 0; other bits read 0. Writing 0 to one of these bits clears its flag, and writing 1 leaves it unchanged.
- R9: A write to offset 0x0C pulses tx_strobe for one cycle in the next cycle, with tx_data equal to the written byte, and clears transmit-data-empty.
- R10: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit-end and transmit-data-empty. A control write with bit 5 = 0 sets transmit-end.
- R11: A pop from an empty FIFO returns 0x00 and changes nothing. A push and a pop in the same cycle leave the count unchanged.
- R12: bus_rdata is registered. It carries the value one cycle after bus_re and is 0x00 in any cycle that follows no read. Unmapped offsets and the write-only offsets 0x0C and 0x18 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver enabled |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench drives the FIFO past full. A design that wrapped its count or overwrote the oldest entry would return the wrong byte order or a count other than 16. It moves the fill level back and forth across the trigger to expose a flag that tracks the count directly instead of holding with hysteresis, and it makes a push and a pop in the same cycle, where a naive counter would drift. It also checks that the interrupt stays up after pops and falls only on the specified writes, and that the transmit flags re-arm only when status is read with the transmitter enabled.

// File: rtl/serial_port_regs.sv
module serial_port_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_re,
  output logic [7:0]    bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_strobe,
  output logic [7:0]    tx_data,
  output logic          rx_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  localparam logic [AW-1:0] OFS_MODE = AW'(8'h00);
  localparam logic [AW-1:0] OFS_RATE = AW'(8'h04);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] OFS_TXD  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h10);
  localparam logic [AW-1:0] OFS_RXD  = AW'(8'h14);
  localparam logic [AW-1:0] OFS_FCTL = AW'(8'h18);
  localparam logic [AW-1:0] OFS_CNT  = AW'(8'h1C);
  localparam logic [AW-1:0] OFS_PORT = AW'(8'h20);

  logic [7:0]    mode_q, rate_q, ctrl_q, port_q;
  logic [1:0]    tsel_q;
  logic          tend_q, tde_q, brk_q, rdf_q, dr_q, irq_q;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt, cnt_n, trig;
  logic [7:0]    rmux;

  wire wr_ctrl  = bus_we && bus_addr == OFS_CTRL;
  wire wr_stat  = bus_we && bus_addr == OFS_STAT;
  wire wr_txd   = bus_we && bus_addr == OFS_TXD;
  wire wr_fctl  = bus_we && bus_addr == OFS_FCTL;
  wire fifo_clr = wr_fctl && bus_wdata[1];
  wire rd_stat  = bus_re && bus_addr == OFS_STAT;
  wire pop      = bus_re && bus_addr == OFS_RXD && cnt != '0 && !fifo_clr;
  wire push     = ctrl_q[4] && rx_valid && cnt < CW'(DEPTH) && !fifo_clr;
  wire hit_trig = push && cnt_n >= trig;

  assign rx_ready = ctrl_q[4];
  assign rx_irq   = irq_q;

  always_comb begin
    case (tsel_q)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase
  end

  always_comb begin
    if (fifo_clr) cnt_n = '0;
    else          cnt_n = cnt + CW'(push) - CW'(pop);
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: rmux = mode_q;
      OFS_RATE: rmux = rate_q;
      OFS_CTRL: rmux = ctrl_q;
      OFS_STAT: rmux = {1'b0, tend_q, tde_q, brk_q, 2'b00, rdf_q, dr_q};
      OFS_RXD:  rmux = (cnt != '0) ? mem[tail] : 8'h00;
      OFS_CNT:  rmux = 8'(cnt);
      OFS_PORT: rmux = port_q;
      default:  rmux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[head] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_n;
      if (fifo_clr) begin
        head <= '0;
        tail <= '0;
      end else begin
        if (push) head <= head + 1'b1;
        if (pop)  tail <= tail + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00;
      rate_q <= 8'hFF;
      ctrl_q <= 8'h20;
      port_q <= 8'h00;
      tsel_q <= 2'd0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_MODE: mode_q <= bus_wdata & 8'h7B;
        OFS_RATE: rate_q <= bus_wdata;
        OFS_CTRL: ctrl_q <= bus_wdata & 8'hFA;
        OFS_FCTL: tsel_q <= bus_wdata[7:6];
        OFS_PORT: port_q <= bus_wdata & 8'hF3;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      tde_q  <= 1'b1;
      brk_q  <= 1'b0;
      rdf_q  <= 1'b0;
      dr_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (fifo_clr)                rdf_q <= 1'b0;
      else if (hit_trig)           rdf_q <= 1'b1;
      else if (pop && cnt_n < trig) rdf_q <= 1'b0;
      if (hit_trig && ctrl_q[6])   irq_q <= 1'b1;
      if (rd_stat && ctrl_q[5]) begin
        tend_q <= 1'b1;
        tde_q  <= 1'b1;
      end
      if (wr_ctrl && !bus_wdata[5]) tend_q <= 1'b1;
      if (wr_txd) tde_q <= 1'b0;
      if (wr_stat) begin
        if (!bus_wdata[6]) tend_q <= 1'b0;
        if (!bus_wdata[5]) tde_q  <= 1'b0;
        if (!bus_wdata[4]) brk_q  <= 1'b0;
        if (!bus_wdata[1]) rdf_q  <= 1'b0;
        if (!bus_wdata[0]) dr_q   <= 1'b0;
      end
      if ((wr_ctrl && !bus_wdata[6]) || (wr_stat && !(bus_wdata[1] && bus_wdata[0])))
        irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      tx_strobe <= 1'b0;
      tx_data   <= 8'h00;
    end else begin
      bus_rdata <= bus_re ? rmux : 8'h00;
      tx_strobe <= wr_txd;
      if (wr_txd) tx_data <= bus_wdata;
    end
  end
endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 6,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [7:0]    bus_wdata,
  input logic          bus_re,
  input logic [7:0]    bus_rdata,
  input logic          tx_strobe,
  input logic [7:0]    tx_data,
  input logic          rx_irq,
  input logic [7:0]    ctrl_q,
  input logic [CW-1:0] cnt
);
  wire a_pop = bus_re && bus_addr == AW'(8'h14);
  wire a_clr = bus_we && bus_addr == AW'(8'h18) && bus_wdata[1];

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !a_pop && !a_clr) |=> cnt == CW'(DEPTH));

  assert_rx_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[4] && !a_pop && !a_clr) |=> $stable(cnt));

  assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8'h0C)) |=> (tx_strobe && tx_data == $past(bus_wdata)));

  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(8'h0C)) |=> !tx_strobe);

  assert_irq_ctrl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8'h08) && !bus_wdata[6]) |=> !rx_irq);

  assert_irq_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8'h10) && !(bus_wdata[1] && bus_wdata[0])) |=> !rx_irq);

  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == 8'h00);
endmodule

bind serial_port_regs serial_port_regs_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .tx_strobe(tx_strobe), .tx_data(tx_data), .rx_irq(rx_irq),
  .ctrl_q(ctrl_q), .cnt(cnt)
);

// File: tb/serial_port_regs_tb_top.sv
module serial_port_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0, rx_valid = 1'b0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data;
  logic rx_ready, tx_strobe, rx_irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  serial_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_data(tx_data), .rx_irq(rx_irq)
  );

  // behavioural reference model
  logic [7:0] m_mode, m_rate, m_ctrl, m_port;
  int m_trig;
  logic [7:0] q[$];
  bit m_tend, m_tde, m_brk, m_rdf, m_dr, m_irq;
  logic [7:0] e_rdata, e_txd;
  bit e_txs;

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mode;
      6'h04: return m_rate;
      6'h08: return m_ctrl;
      6'h10: return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
      6'h14: return (q.size() > 0) ? q[0] : 8'h00;
      6'h1C: return 8'(q.size());
      6'h20: return m_port;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int trig_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit pu, po, cl;
    int n;
    logic [7:0] tmp;
    if (!rst_n) begin
      m_mode = 0; m_rate = 8'hFF; m_ctrl = 8'h20; m_port = 0; m_trig = 1;
      q.delete();
      m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_irq = 0;
      e_rdata = 0; e_txd = 0; e_txs = 0;
    end else begin
      cl = bus_we && bus_addr == 6'h18 && bus_wdata[1];
      po = bus_re && bus_addr == 6'h14 && q.size() > 0 && !cl;
      pu = m_ctrl[4] && rx_valid && q.size() < 16 && !cl;
      e_rdata = bus_re ? m_read(bus_addr) : 8'h00;
      e_txs = bus_we && bus_addr == 6'h0C;
      if (e_txs) e_txd = bus_wdata;
      if (po) tmp = q.pop_front();
      if (pu) q.push_back(rx_data);
      if (cl) q.delete();
      n = q.size();
      if (cl) m_rdf = 0;
      else if (pu && n >= m_trig) m_rdf = 1;
      else if (po && n < m_trig) m_rdf = 0;
      if (pu && n >= m_trig && m_ctrl[6]) m_irq = 1;
      if (bus_re && bus_addr == 6'h10 && m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
      if (bus_we) begin
        case (bus_addr)
          6'h00: m_mode = bus_wdata & 8'h7B;
          6'h04: m_rate = bus_wdata;
          6'h08: begin
            m_ctrl = bus_wdata & 8'hFA;
            if (!bus_wdata[5]) m_tend = 1;
            if (!bus_wdata[6]) m_irq = 0;
          end
          6'h0C: m_tde = 0;
          6'h10: begin
            if (!bus_wdata[6]) m_tend = 0;
            if (!bus_wdata[5]) m_tde = 0;
            if (!bus_wdata[4]) m_brk = 0;
            if (!bus_wdata[1]) m_rdf = 0;
            if (!bus_wdata[0]) m_dr = 0;
            if (!bus_wdata[1] || !bus_wdata[0]) m_irq = 0;
          end
          6'h18: m_trig = trig_of(bus_wdata[7:6]);
          6'h20: m_port = bus_wdata & 8'hF3;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_rdata == e_rdata, cur_req, "model rdata", bus_rdata, e_rdata);
      chk(tx_strobe == e_txs, cur_req, "model tx_strobe", tx_strobe, e_txs);
      if (e_txs) chk(tx_data == e_txd, cur_req, "model tx_data", tx_data, e_txd);
      chk(rx_irq == m_irq, cur_req, "model rx_irq", rx_irq, m_irq);
      chk(rx_ready == m_ctrl[4], cur_req, "model rx_ready", rx_ready, m_ctrl[4]);
    end
  end

  task automatic cyc(input logic [5:0] a, input bit we, input logic [7:0] wd,
                     input bit re, input bit rv, input logic [7:0] rd);
    @(negedge clk);
    #1;
    bus_addr = a; bus_we = we; bus_wdata = wd; bus_re = re;
    rx_valid = rv; rx_data = rd;
  endtask

  task automatic idle();
    cyc(6'h00, 0, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    cyc(a, 1, d, 0, 0, 8'h00);
  endtask

  task automatic push(input logic [7:0] d);
    cyc(6'h00, 0, 8'h00, 0, 1, d);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] mask,
                        input logic [7:0] exp, input string req);
    cyc(a, 0, 8'h00, 1, 0, 8'h00);
    idle();
    chk((bus_rdata & mask) == exp, req, $sformatf("read 0x%02h", a),
        bus_rdata & mask, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rd_chk(6'h04, 8'hFF, 8'hFF, "R1");
    rd_chk(6'h08, 8'hFF, 8'h20, "R1");
    rd_chk(6'h00, 8'hFF, 8'h00, "R1");
    rd_chk(6'h20, 8'hFF, 8'h00, "R1");
    rd_chk(6'h10, 8'hFF, 8'h60, "R1");
    rd_chk(6'h1C, 8'hFF, 8'h00, "R1");
    chk(rx_irq == 1'b0, "R1", "irq after reset", rx_irq, 0);

    cur_req = "R12";
    rd_chk(6'h24, 8'hFF, 8'h00, "R12");
    rd_chk(6'h0C, 8'hFF, 8'h00, "R12");
    rd_chk(6'h18, 8'hFF, 8'h00, "R12");

    cur_req = "R2";
    wr(6'h00, 8'hFF); rd_chk(6'h00, 8'hFF, 8'h7B, "R2");
    wr(6'h08, 8'hFF); rd_chk(6'h08, 8'hFF, 8'hFA, "R2");
    wr(6'h20, 8'hFF); rd_chk(6'h20, 8'hFF, 8'hF3, "R2");

    cur_req = "R9";
    wr(6'h0C, 8'hA5);
    idle();
    chk(tx_strobe == 1'b1 && tx_data == 8'hA5, "R9", "tx pulse", {tx_strobe, tx_data}, 9'h1A5);
    idle();
    chk(tx_strobe == 1'b0, "R9", "tx pulse width", tx_strobe, 0);
    rd_chk(6'h10, 8'hFF, 8'h40, "R9");

    cur_req = "R10";
    rd_chk(6'h10, 8'hFF, 8'h60, "R10");
    wr(6'h08, 8'h10);
    wr(6'h10, 8'h00);
    rd_chk(6'h10, 8'hFF, 8'h00, "R10");
    rd_chk(6'h10, 8'hFF, 8'h00, "R10");
    wr(6'h08, 8'h10);
    rd_chk(6'h10, 8'hFF, 8'h40, "R10");

    cur_req = "R8";
    wr(6'h10, 8'hFF); rd_chk(6'h10, 8'hFF, 8'h40, "R8");
    wr(6'h10, 8'hBF); rd_chk(6'h10, 8'hFF, 8'h00, "R8");

    cur_req = "R5";
    wr(6'h08, 8'h00);
    idle();
    chk(rx_ready == 1'b0, "R5", "ready with rx off", rx_ready, 0);
    push(8'h11);
    rd_chk(6'h1C, 8'hFF, 8'h00, "R5");

    cur_req = "R4";
    wr(6'h08, 8'h10);
    wr(6'h18, 8'h00);
    for (int i = 0; i < 18; i++) push(8'h30 + 8'(i));
    rd_chk(6'h1C, 8'hFF, 8'h10, "R4");
    for (int i = 0; i < 16; i++) rd_chk(6'h14, 8'hFF, 8'h30 + 8'(i), "R4");
    rd_chk(6'h1C, 8'hFF, 8'h00, "R4");

    cur_req = "R11";
    rd_chk(6'h14, 8'hFF, 8'h00, "R11");
    rd_chk(6'h1C, 8'hFF, 8'h00, "R11");

    cur_req = "R6";
    wr(6'h18, 8'h80);
    for (int i = 0; i < 7; i++) push(8'h50 + 8'(i));
    rd_chk(6'h10, 8'h02, 8'h00, "R6");
    push(8'h57);
    rd_chk(6'h10, 8'h02, 8'h02, "R6");
    rd_chk(6'h14, 8'hFF, 8'h50, "R6");
    rd_chk(6'h10, 8'h02, 8'h00, "R6");
    push(8'h60);
    cur_req = "R11";
    cyc(6'h14, 0, 8'h00, 1, 1, 8'h61);
    idle();
    chk(bus_rdata == 8'h51, "R11", "pop during push", bus_rdata, 8'h51);
    rd_chk(6'h1C, 8'hFF, 8'h08, "R11");
    rd_chk(6'h10, 8'h02, 8'h02, "R6");

    cur_req = "R3";
    wr(6'h18, 8'h82);
    rd_chk(6'h1C, 8'hFF, 8'h00, "R3");
    rd_chk(6'h10, 8'h02, 8'h00, "R3");

    cur_req = "R7";
    wr(6'h08, 8'h50);
    wr(6'h18, 8'h40);
    for (int i = 0; i < 3; i++) push(8'h70 + 8'(i));
    idle();
    chk(rx_irq == 1'b0, "R7", "irq below trigger", rx_irq, 0);
    push(8'h73);
    idle();
    chk(rx_irq == 1'b1, "R7", "irq at trigger", rx_irq, 1);
    rd_chk(6'h14, 8'hFF, 8'h70, "R7");
    chk(rx_irq == 1'b1, "R7", "irq held after pop", rx_irq, 1);
    wr(6'h10, 8'hFD);
    idle();
    chk(rx_irq == 1'b0, "R7", "irq status clear", rx_irq, 0);
    push(8'h74);
    idle();
    chk(rx_irq == 1'b1, "R7", "irq reassert", rx_irq, 1);
    wr(6'h08, 8'h10);
    idle();
    chk(rx_irq == 1'b0, "R7", "irq ctrl clear", rx_irq, 0);
    wr(6'h08, 8'h50);
    push(8'h75);
    idle();
    chk(rx_irq == 1'b1, "R7", "irq set again", rx_irq, 1);
    wr(6'h10, 8'hFE);
    idle();
    chk(rx_irq == 1'b0, "R7", "irq clear bit0", rx_irq, 0);

    cur_req = "R3";
    wr(6'h18, 8'hC2);
    for (int i = 0; i < 13; i++) push(8'h80 + 8'(i));
    rd_chk(6'h10, 8'h02, 8'h00, "R3");
    push(8'h8D);
    rd_chk(6'h10, 8'h02, 8'h02, "R3");
    rd_chk(6'h1C, 8'hFF, 8'h0E, "R3");

    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule